// File: doc/BRIEF.md
# Duty-Cycled Sampling Window Controller

This block sequences the front end of a pulse-radio receiver from a single base clock. The timeline repeats once per symbol. At a programmable offset into each symbol it opens a sampling window of programmable length. Each front-end sub-block (clock input buffer, analog biases, ADC sampling) has its own enable output. That enable rises a programmable number of cycles before the window and falls a programmable number of cycles after it. As a result, each sub-block is duty-cycled on its own, and the receiver can idle between windows.

At the start of each window the block issues one ADC strobe for every delay-line phase selected in a mask. Those phase taps come from an external 32-stage delay-locked line. The ADC returns each phase's result with its own latency. The block captures these staggered results on the base clock and packs them into one parallel word per window, with a one-cycle valid pulse. A phase that has not reported by the end of the window produces an error pulse instead of a word.

When the repeat period equals the window length, or when the settings do not fit into the period, the controller runs always-on. In always-on mode every enable stays high and back-to-back windows span whole symbols. In duty-cycled mode the delay line is powered down between windows. For that reason an extra settle interval is placed between the start of the enables and the strobe.

Top module: `swin_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `fe_en`, `adc_strobe`, `word_valid`, `window_err` and `word_data` are all zero.
- R2: The timing settings (`cfg_period`, `cfg_offset`, `cfg_width`, `cfg_settle`, `cfg_lead`, `cfg_lag`, `cfg_phase_sel`) are sampled only on the first cycle after reset and on the last cycle of each symbol. A change at any other time has no effect until the next such cycle.
- R3: In duty-cycled mode, with c the cycle index inside the symbol (0 to period-1), enable k (lead in `cfg_lead[k*LW +: LW]`, lag in `cfg_lag[k*LW +: LW]`) is high exactly when offset - lead_k <= c < offset + settle + width + lag_k.
- R4: `adc_strobe` equals the phase-select mask for exactly one cycle per symbol and is zero otherwise. That cycle is c = offset + settle in duty-cycled mode and c = 0 in always-on mode.
- R5: In always-on mode every enable is high on every cycle after the first. The window covers c = 0 to period-1, and no settle interval is applied.
- R6: Duty-cycled mode is chosen only when all of the following hold: 1 <= width < period, offset >= every lead, and offset + settle + width + the largest lag <= period. Otherwise the controller runs always-on.
- R7: During window cycles, a ready on a selected phase p stores `adc_sample[p*SW +: SW]` into the same field of the word. A later ready in the same window overwrites the earlier one. If every selected phase has reported in this window, `word_valid` pulses for one cycle on the cycle after the last window cycle, carrying the word.
- R8: If any selected phase has not reported within the window, because it was missing or arrived after the close, `window_err` pulses for one cycle in place of `word_valid`, and `word_data` keeps its previous value.
- R9: Ready and sample inputs on unselected phases, and any ready outside the window, are ignored. The fields of unselected phases in a published word are zero.
- R10: Each window ends in exactly one of `word_valid` or `window_err`, never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CW | Symbol / repeat period in cycles (0 acts as 1) |
| cfg_offset | input | CW | Window offset from the symbol start |
| cfg_width | input | CW | Sampling window length in cycles |
| cfg_settle | input | CW | Extra cycles before the strobe in duty-cycled mode |
| cfg_lead | input | NEN*LW | Per-enable lead before the window, LW bits each |
| cfg_lag | input | NEN*LW | Per-enable lag after the window, LW bits each |
| cfg_phase_sel | input | TAPS | Mask of delay-line phases to strobe and collect |
| fe_en | output | NEN | Front-end enable outputs |
| adc_strobe | output | TAPS | One-cycle sample strobe per selected phase |
| adc_ready | input | TAPS | Per-phase result-ready pulse from the ADC |
| adc_sample | input | TAPS*SW | Per-phase ADC results |
| word_data | output | TAPS*SW | Aligned output word |
| word_valid | output | 1 | One-cycle pulse when a complete word is published |
| window_err | output | 1 | One-cycle pulse when a window ends incomplete |

## Verification
The hardest situation to reach is a settings change that arrives in the middle of a symbol. The old and new settings must both be visible on the enables in the right cycles, which requires that the change straddle a wrap. The bench rewrites the offset and width at an arbitrary cycle and lets a behavioural model, which loads its copy only at the wrap, predict every cycle. Incomplete windows need an ADC that misbehaves on purpose, so the bench's ADC model can drop one phase or return it long after the window closes. The rejection rule is reached with settings whose lead or lag no longer fit inside the period.

// File: rtl/swin_ctrl.sv
module swin_ctrl #(
  parameter int TAPS = 32,
  parameter int SW   = 1,
  parameter int NEN  = 4,
  parameter int CW   = 18,
  parameter int LW   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        cfg_period,
  input  logic [CW-1:0]        cfg_offset,
  input  logic [CW-1:0]        cfg_width,
  input  logic [CW-1:0]        cfg_settle,
  input  logic [NEN*LW-1:0]    cfg_lead,
  input  logic [NEN*LW-1:0]    cfg_lag,
  input  logic [TAPS-1:0]      cfg_phase_sel,
  output logic [NEN-1:0]       fe_en,
  output logic [TAPS-1:0]      adc_strobe,
  input  logic [TAPS-1:0]      adc_ready,
  input  logic [TAPS*SW-1:0]   adc_sample,
  output logic [TAPS*SW-1:0]   word_data,
  output logic                 word_valid,
  output logic                 window_err
);
  localparam int XW = CW + LW + 2;
  localparam int DW = TAPS * SW;

  logic              init, s_duty, cfg_duty;
  logic [CW-1:0]     cnt, s_per, s_off, s_win, s_set;
  logic [NEN*LW-1:0] s_lead, s_lag;
  logic [TAPS-1:0]   s_sel, got, got_n;
  logic [DW-1:0]     cap, cap_n, selx;
  logic [LW-1:0]     mx_lead, mx_lag;
  logic [XW-1:0]     need, cntx, w0, wend;
  logic              wrap, inwin, opn, cls, all_in;

  always_comb begin
    mx_lead = '0;
    mx_lag  = '0;
    for (int k = 0; k < NEN; k++) begin
      if (cfg_lead[k*LW +: LW] > mx_lead) mx_lead = cfg_lead[k*LW +: LW];
      if (cfg_lag[k*LW +: LW]  > mx_lag)  mx_lag  = cfg_lag[k*LW +: LW];
    end
  end

  assign need = XW'(cfg_offset) + XW'(cfg_settle) + XW'(cfg_width) + XW'(mx_lag);
  assign cfg_duty = (cfg_width != '0) && (cfg_width < cfg_period) &&
                    (XW'(cfg_offset) >= XW'(mx_lead)) && (need <= XW'(cfg_period));

  assign wrap = init || (cnt == s_per - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init   <= 1'b1;
      cnt    <= '0;
      s_per  <= '0;
      s_off  <= '0;
      s_win  <= '0;
      s_set  <= '0;
      s_lead <= '0;
      s_lag  <= '0;
      s_sel  <= '0;
      s_duty <= 1'b0;
    end else if (wrap) begin
      init   <= 1'b0;
      cnt    <= '0;
      s_per  <= (cfg_period == '0) ? CW'(1) : cfg_period;
      s_off  <= cfg_offset;
      s_win  <= cfg_width;
      s_set  <= cfg_settle;
      s_lead <= cfg_lead;
      s_lag  <= cfg_lag;
      s_sel  <= cfg_phase_sel;
      s_duty <= cfg_duty;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntx  = XW'(cnt);
  assign w0    = s_duty ? XW'(s_off) + XW'(s_set) : '0;
  assign wend  = w0 + (s_duty ? XW'(s_win) : XW'(s_per));
  assign inwin = !init && (cntx >= w0) && (cntx < wend);
  assign opn   = !init && (cntx == w0);
  assign cls   = !init && (cntx == wend - 1'b1);

  for (genvar k = 0; k < NEN; k++) begin : g_en
    logic [XW-1:0] lo, hi;
    assign lo = XW'(s_off) - XW'(s_lead[k*LW +: LW]);
    assign hi = XW'(s_off) + XW'(s_set) + XW'(s_win) + XW'(s_lag[k*LW +: LW]);
    assign fe_en[k] = !init && (!s_duty || ((cntx >= lo) && (cntx < hi)));
  end

  assign adc_strobe = opn ? s_sel : '0;

  for (genvar p = 0; p < TAPS; p++) begin : g_ph
    logic take;
    assign take     = inwin && adc_ready[p] && s_sel[p];
    assign got_n[p] = take || (got[p] && !opn);
    assign cap_n[p*SW +: SW] = take ? adc_sample[p*SW +: SW] :
                               (opn ? '0 : cap[p*SW +: SW]);
    assign selx[p*SW +: SW]  = {SW{s_sel[p]}};
  end

  assign all_in = &(got_n | ~s_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got        <= '0;
      cap        <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
      window_err <= 1'b0;
    end else begin
      got        <= got_n;
      cap        <= cap_n;
      word_valid <= cls && all_in;
      window_err <= cls && !all_in;
      if (cls && all_in) word_data <= cap_n;
    end
  end

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && cnt != '0) |-> ($stable(s_per) && $stable(s_off) && $stable(s_win) &&
                              $stable(s_set) && $stable(s_sel) && $stable(s_duty)));

  assert_enables_cover_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|adc_strobe) |-> (&fe_en));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|adc_strobe) && s_duty) |=> !(|adc_strobe));

  assert_unselected_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ((word_data & ~$past(selx)) == '0));

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && window_err));
endmodule

// File: tb/swin_ctrl_test.sv
`timescale 1ns/1ps
module swin_ctrl_test;
  localparam int TAPS = 32, SW = 1, NEN = 4, CW = 18, LW = 6;
  localparam int DW = TAPS * SW;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cfg_period, cfg_offset, cfg_width, cfg_settle;
  logic [NEN*LW-1:0] cfg_lead, cfg_lag;
  logic [TAPS-1:0] cfg_phase_sel;
  logic [NEN-1:0] fe_en;
  logic [TAPS-1:0] adc_strobe, adc_ready;
  logic [DW-1:0] adc_sample, word_data;
  logic word_valid, window_err;

  swin_ctrl #(.TAPS(TAPS), .SW(SW), .NEN(NEN), .CW(CW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_offset(cfg_offset),
    .cfg_width(cfg_width), .cfg_settle(cfg_settle), .cfg_lead(cfg_lead), .cfg_lag(cfg_lag),
    .cfg_phase_sel(cfg_phase_sel), .fe_en(fe_en), .adc_strobe(adc_strobe),
    .adc_ready(adc_ready), .adc_sample(adc_sample), .word_data(word_data),
    .word_valid(word_valid), .window_err(window_err));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;
  string scen = "R1";
  int adc_mode = 0;

  // behavioural reference state
  int m_cnt, p_per, p_off, p_win, p_set;
  int p_lead[NEN], p_lag[NEN];
  bit m_init, p_duty, m_vld, m_err;
  bit [TAPS-1:0] p_sel, m_got;
  bit [DW-1:0] m_cap, m_word;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (scenario %s) %s: actual %h expected %h", req, scen, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int win_start();
    return p_duty ? p_off + p_set : 0;
  endfunction
  function automatic int win_len();
    return p_duty ? p_win : p_per;
  endfunction

  function automatic bit [NEN-1:0] exp_en();
    bit [NEN-1:0] e;
    for (int k = 0; k < NEN; k++)
      e[k] = !m_init && (!p_duty || (m_cnt >= p_off - p_lead[k] &&
                                      m_cnt < p_off + p_set + p_win + p_lag[k]));
    return e;
  endfunction

  function automatic bit [TAPS-1:0] exp_strobe();
    return (!m_init && m_cnt == win_start()) ? p_sel : '0;
  endfunction

  always @(posedge clk) begin : model
    int w0, wl, ml, mg, per;
    bit inw, op, cl;
    bit [TAPS-1:0] g;
    bit [DW-1:0] c;
    if (!rst_n) begin
      m_init = 1; m_cnt = 0; m_got = '0; m_cap = '0; m_word = '0;
      m_vld = 0; m_err = 0; p_duty = 0; p_sel = '0;
      p_per = 0; p_off = 0; p_win = 0; p_set = 0;
      for (int k = 0; k < NEN; k++) begin p_lead[k] = 0; p_lag[k] = 0; end
    end else begin
      w0 = win_start(); wl = win_len();
      inw = !m_init && m_cnt >= w0 && m_cnt < w0 + wl;
      op  = !m_init && m_cnt == w0;
      cl  = !m_init && m_cnt == w0 + wl - 1;
      g = op ? '0 : m_got;
      c = op ? '0 : m_cap;
      if (inw)
        for (int p = 0; p < TAPS; p++)
          if (adc_ready[p] && p_sel[p]) begin
            g[p] = 1;
            c[p*SW +: SW] = adc_sample[p*SW +: SW];
          end
      m_got = g; m_cap = c;
      m_vld = 0; m_err = 0;
      if (cl) begin
        if ((g | ~p_sel) == '1) begin m_vld = 1; m_word = c; end
        else m_err = 1;
      end
      if (m_init || m_cnt == p_per - 1) begin
        m_init = 0; m_cnt = 0;
        per = (cfg_period == 0) ? 1 : int'(cfg_period);
        p_per = per; p_off = int'(cfg_offset); p_win = int'(cfg_width);
        p_set = int'(cfg_settle); p_sel = cfg_phase_sel;
        ml = 0; mg = 0;
        for (int k = 0; k < NEN; k++) begin
          p_lead[k] = int'(cfg_lead[k*LW +: LW]);
          p_lag[k]  = int'(cfg_lag[k*LW +: LW]);
          if (p_lead[k] > ml) ml = p_lead[k];
          if (p_lag[k] > mg) mg = p_lag[k];
        end
        p_duty = (p_win >= 1) && (p_win < int'(cfg_period)) && (p_off >= ml) &&
                 (p_off + p_set + p_win + mg <= int'(cfg_period));
      end else begin
        m_cnt++;
      end
    end
  end

  // ADC stand-in: per-phase latency after its strobe
  int tmr[TAPS];
  always @(negedge clk) begin
    adc_ready = '0;
    if (!rst_n) begin
      for (int p = 0; p < TAPS; p++) tmr[p] = 0;
      adc_sample = '0;
    end else begin
      for (int p = 0; p < TAPS; p++) begin
        if (adc_strobe[p]) begin
          tmr[p] = 1 + (p % 4);
          if (p == 5 && adc_mode == 1) tmr[p] = -1;
          if (p == 5 && adc_mode == 2) tmr[p] = 20;
        end else if (tmr[p] > 0) begin
          tmr[p]--;
          if (tmr[p] == 0) begin
            adc_ready[p] = 1'b1;
            adc_sample[p*SW +: SW] = SW'($urandom);
          end
        end
      end
      // noise on unselected phases (R9)
      for (int p = 0; p < TAPS; p++)
        if (!p_sel[p] && ($urandom % 5 == 0)) begin
          adc_ready[p] = 1'b1;
          adc_sample[p*SW +: SW] = SW'($urandom);
        end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      check(fe_en == exp_en(), p_duty ? "R3" : "R5", "enables", 64'(fe_en), 64'(exp_en()));
      check(adc_strobe == exp_strobe(), "R4", "strobe", 64'(adc_strobe), 64'(exp_strobe()));
      check(word_valid == m_vld, "R7", "valid", 64'(word_valid), 64'(m_vld));
      check(window_err == m_err, "R8", "error", 64'(window_err), 64'(m_err));
      check(word_data == m_word, "R7", "word", 64'(word_data), 64'(m_word));
      check(!(word_valid && window_err), "R10", "both outcomes", 64'({word_valid, window_err}), 64'(0));
    end
  end

  task automatic set_cfg(input int per, input int off, input int win, input int st,
                         input logic [TAPS-1:0] sel,
                         input int l0, input int l1, input int l2, input int l3,
                         input int g0, input int g1, input int g2, input int g3);
    cfg_period = CW'(per); cfg_offset = CW'(off); cfg_width = CW'(win);
    cfg_settle = CW'(st); cfg_phase_sel = sel;
    cfg_lead = {LW'(l3), LW'(l2), LW'(l1), LW'(l0)};
    cfg_lag  = {LW'(g3), LW'(g2), LW'(g1), LW'(g0)};
  endtask

  initial begin
    set_cfg(60, 10, 13, 4, 32'hFFFF_FFFF, 2, 4, 6, 8, 1, 3, 0, 5);
    repeat (5) @(negedge clk);
    check(fe_en == '0 && adc_strobe == '0, "R1", "enables/strobe in reset",
          64'({fe_en, adc_strobe}), 64'(0));
    check(!word_valid && !window_err && word_data == '0, "R1", "outputs in reset",
          64'({word_valid, window_err, word_data}), 64'(0));
    rst_n = 1;
    @(negedge clk);
    check(fe_en == '0 && adc_strobe == '0 && !word_valid, "R1", "first cycle after reset",
          64'({fe_en, adc_strobe, word_valid}), 64'(0));
    cmp_on = 1;
    scen = "R3"; repeat (200) @(negedge clk);
    scen = "R9"; cfg_phase_sel = 32'h0F0F_00F3; repeat (180) @(negedge clk);
    scen = "R8"; cfg_phase_sel = 32'hFFFF_FFFF;
    adc_mode = 1; repeat (180) @(negedge clk);
    adc_mode = 2; repeat (180) @(negedge clk);
    adc_mode = 0; repeat (120) @(negedge clk);
    scen = "R2";
    repeat (23) @(negedge clk);
    cfg_offset = CW'(20); cfg_width = CW'(8);
    repeat (7) @(negedge clk);
    cfg_settle = CW'(2);
    repeat (200) @(negedge clk);
    scen = "R5"; set_cfg(16, 3, 16, 4, 32'hA5A5_5A5A, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (120) @(negedge clk);
    scen = "R6"; set_cfg(20, 10, 13, 4, 32'hFFFF_0000, 2, 4, 6, 8, 1, 3, 0, 5);
    repeat (150) @(negedge clk);
    set_cfg(100, 3, 13, 4, 32'h0000_FFFF, 2, 4, 6, 8, 1, 3, 0, 5);
    repeat (250) @(negedge clk);
    scen = "R7"; set_cfg(60, 10, 13, 4, 32'hFFFF_FFFF, 2, 4, 6, 8, 1, 3, 0, 5);
    repeat (200) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual still running expected finished");
      finish_run();
    end
  end
endmodule